// File: doc/BRIEF.md
# Subword-Parallel Complex Multiply-Accumulate Unit

This datapath block serves symbol-rate baseband work on in-phase/quadrature samples. Each 16-bit operand carries two signed bytes: the in-phase sample sits in the upper byte and the quadrature sample in the lower byte. Four signed 8x8 multipliers sit behind an operand crossbar. The mode select regroups them into one of four operations, and each operation issues in a single cycle:

- a complex multiply, which returns packed real and imaginary 16-bit words;
- a complex multiply-accumulate, which folds both parts into split halves of a 40-bit accumulator;
- a two-tap FIR step, which adds two byte products into the full-width accumulator;
- an energy step, which accumulates I² + Q² of a single operand.

A controller issues one operation per cycle by raising `en`. It reads the products on `re_out`/`im_out` and the running sums on `acc_out` one cycle later. The controller uses `acc_clr` to start a new sum without spending an extra cycle.

Top module: `cmac_unit`

## Requirements
- R1: In an operand, bits [15:8] hold the signed in-phase byte and bits [7:0] hold the signed quadrature byte. `mode` encodes 0 = complex multiply, 1 = complex MAC, 2 = dual FIR step, 3 = energy step.
- R2: While `rst_n` is low, `re_out`, `im_out` and `acc_out` are all zero.
- R3: A complex-multiply issue (mode 0) sets `re_out` to Ia·Ib − Qa·Qb and `im_out` to Ia·Qb + Qa·Ib, each kept modulo 2^16. `acc_out` does not change unless `acc_clr` is high.
- R4: A complex-MAC issue (mode 1) updates `re_out`/`im_out` as in R3. It adds the sign-extended real result to `acc_out[39:20]` and the sign-extended imaginary result to `acc_out[19:0]`. Each half wraps modulo 2^20, and no carry or borrow crosses between the halves.
- R5: A dual-FIR issue (mode 2) adds Ia·Ib + Qa·Qb, sign-extended, to the whole 40-bit `acc_out` modulo 2^40. `re_out` and `im_out` keep their values.
- R6: An energy issue (mode 3) adds Ia·Ia + Qa·Qa to `acc_out`. `op_b` has no effect on the result, and `re_out`/`im_out` keep their values.
- R7: When `acc_clr` is high together with an accumulating issue (mode 1, 2 or 3), the new accumulator equals that issue's contribution added to zero. When `acc_clr` is high in any other cycle, `acc_out` is zero on the next cycle.
- R8: While `en` is low, `mode`, `op_a` and `op_b` are ignored. `re_out` and `im_out` hold, and `acc_out` holds unless R7 clears it.
- R9: Every result appears on the outputs exactly one clock edge after its issue and is not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Issue strobe for the operation on `mode`, `op_a`, `op_b` |
| mode | input | 2 | Operation select (R1 encoding) |
| acc_clr | input | 1 | Clear the accumulator base |
| op_a | input | 16 | Packed I/Q operand A |
| op_b | input | 16 | Packed I/Q operand B |
| re_out | output | 16 | Registered real part of the last complex issue |
| im_out | output | 16 | Registered imaginary part of the last complex issue |
| acc_out | output | 40 | Accumulator |

## Verification
The bench aims at the arithmetic extremes. Two −128 bytes push the imaginary sum to +32768. A design with the wrong width or signedness there would show the wrong sign or a stray carry, when the correct result wraps to 0x8000. A long run of large real complex-MAC terms forces the upper accumulator half past 2^20. A design that treated the accumulator as one 40-bit adder would leak that carry upward or disturb the imaginary half. Further directed issues cover the cases that show up only in one lane or one mode:
- a mixed-sign FIR sum, which catches a zero-extended product;
- an energy issue with an active `op_b`, which catches a crossbar that does not route A to both ports;
- clears in idle cycles;
- the early-sample check, which would reveal a combinational path past the output register.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  typedef enum logic [1:0] {
    MD_CMUL = 2'd0,
    MD_CMAC = 2'd1,
    MD_FIR  = 2'd2,
    MD_POW  = 2'd3
  } cmac_mode_e;

  localparam int unsigned NUM_MUL = 4;
endpackage

// File: rtl/cmac_xbar.sv
module cmac_xbar
  import cmac_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned WORD_W = 2 * LANE_W
) (
  input  logic                              en,
  input  cmac_mode_e                        md,
  input  logic [WORD_W-1:0]                 op_a,
  input  logic [WORD_W-1:0]                 op_b,
  output logic [NUM_MUL-1:0][LANE_W-1:0]    mul_x,
  output logic [NUM_MUL-1:0][LANE_W-1:0]    mul_y
);
  logic [WORD_W-1:0] b_src;
  logic [LANE_W-1:0] a_i, a_q, b_i, b_q;
  logic              cross_on;
  logic              direct_on;

  // energy mode drives operand A into both multiplier ports
  assign b_src     = (md == MD_POW) ? op_a : op_b;
  assign a_i       = op_a[WORD_W-1:LANE_W];
  assign a_q       = op_a[LANE_W-1:0];
  assign b_i       = b_src[WORD_W-1:LANE_W];
  assign b_q       = b_src[LANE_W-1:0];
  assign cross_on  = en && ((md == MD_CMUL) || (md == MD_CMAC));
  assign direct_on = en;

  // operand gating keeps idle multipliers from toggling
  always_comb begin
    mul_x[0] = direct_on ? a_i : '0;
    mul_y[0] = direct_on ? b_i : '0;
    mul_x[1] = direct_on ? a_q : '0;
    mul_y[1] = direct_on ? b_q : '0;
    mul_x[2] = cross_on  ? a_i : '0;
    mul_y[2] = cross_on  ? b_q : '0;
    mul_x[3] = cross_on  ? a_q : '0;
    mul_y[3] = cross_on  ? b_i : '0;
  end
endmodule

// File: rtl/cmac_mularr.sv
module cmac_mularr
  import cmac_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input  logic [NUM_MUL-1:0][LANE_W-1:0] mul_x,
  input  logic [NUM_MUL-1:0][LANE_W-1:0] mul_y,
  output logic [NUM_MUL-1:0][PROD_W-1:0] prod
);
  for (genvar k = 0; k < NUM_MUL; k++) begin : g_mul
    logic signed [PROD_W-1:0] p_s;
    assign p_s     = $signed(mul_x[k]) * $signed(mul_y[k]);
    assign prod[k] = p_s;
  end
endmodule

// File: rtl/cmac_combine.sv
module cmac_combine
  import cmac_pkg::*;
#(
  parameter int unsigned PROD_W = 16,
  localparam int unsigned DOT_W = 2 * PROD_W
) (
  input  logic [NUM_MUL-1:0][PROD_W-1:0] prod,
  output logic [PROD_W-1:0]              re_c,
  output logic [PROD_W-1:0]              im_c,
  output logic [DOT_W-1:0]               dot_c
);
  logic [DOT_W-1:0] p0_x, p1_x;

  assign re_c  = prod[0] - prod[1];
  assign im_c  = prod[2] + prod[3];
  assign p0_x  = {{(DOT_W-PROD_W){prod[0][PROD_W-1]}}, prod[0]};
  assign p1_x  = {{(DOT_W-PROD_W){prod[1][PROD_W-1]}}, prod[1]};
  assign dot_c = p0_x + p1_x;
endmodule

// File: rtl/cmac_acc.sv
module cmac_acc
  import cmac_pkg::*;
#(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned PROD_W = 16,
  localparam int unsigned DOT_W  = 2 * PROD_W,
  localparam int unsigned HALF_W = ACC_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              acc_clr,
  input  cmac_mode_e        md,
  input  logic [PROD_W-1:0] re_c,
  input  logic [PROD_W-1:0] im_c,
  input  logic [DOT_W-1:0]  dot_c,
  output logic [ACC_W-1:0]  acc_q
);
  logic [ACC_W-1:0]  base;
  logic [ACC_W-1:0]  acc_d;
  logic [ACC_W-1:0]  dot_x;
  logic [HALF_W-1:0] hi_d, lo_d;
  logic              acc_ld;

  assign base   = acc_clr ? '0 : acc_q;
  assign dot_x  = {{(ACC_W-DOT_W){dot_c[DOT_W-1]}}, dot_c};
  // halves add separately so no carry crosses bit HALF_W
  assign hi_d   = base[ACC_W-1:HALF_W] + {{(HALF_W-PROD_W){re_c[PROD_W-1]}}, re_c};
  assign lo_d   = base[HALF_W-1:0]     + {{(HALF_W-PROD_W){im_c[PROD_W-1]}}, im_c};
  assign acc_ld = acc_clr || (en && (md != MD_CMUL));

  always_comb begin
    acc_d = base;
    if (en) begin
      unique case (md)
        MD_CMAC:        acc_d = {hi_d, lo_d};
        MD_FIR, MD_POW: acc_d = base + dot_x;
        default:        acc_d = base;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_ld) begin
      acc_q <= acc_d;
    end
  end

  // R8
  acc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !acc_clr) |=> $stable(acc_q));

  // R7
  acc_clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr && (!en || md == MD_CMUL)) |=> (acc_q == '0));

  // R3
  acc_cmul_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !acc_clr && md == MD_CMUL) |=> $stable(acc_q));
endmodule

// File: rtl/cmac_unit.sv
module cmac_unit
  import cmac_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ACC_W  = 40,
  localparam int unsigned WORD_W = 2 * LANE_W,
  localparam int unsigned PROD_W = 2 * LANE_W,
  localparam int unsigned DOT_W  = 2 * PROD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              acc_clr,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [PROD_W-1:0] re_out,
  output logic [PROD_W-1:0] im_out,
  output logic [ACC_W-1:0]  acc_out
);
  cmac_mode_e                    md;
  logic [NUM_MUL-1:0][LANE_W-1:0] mul_x, mul_y;
  logic [NUM_MUL-1:0][PROD_W-1:0] prod;
  logic [PROD_W-1:0]             re_c, im_c;
  logic [DOT_W-1:0]              dot_c;
  logic [PROD_W-1:0]             re_q, im_q, re_d, im_d;
  logic                          cplx_ld;

  assign md = cmac_mode_e'(mode);

  cmac_xbar #(.LANE_W(LANE_W)) i_xbar (
    .en    (en),
    .md    (md),
    .op_a  (op_a),
    .op_b  (op_b),
    .mul_x (mul_x),
    .mul_y (mul_y)
  );

  cmac_mularr #(.LANE_W(LANE_W)) i_mularr (
    .mul_x (mul_x),
    .mul_y (mul_y),
    .prod  (prod)
  );

  cmac_combine #(.PROD_W(PROD_W)) i_combine (
    .prod  (prod),
    .re_c  (re_c),
    .im_c  (im_c),
    .dot_c (dot_c)
  );

  cmac_acc #(.ACC_W(ACC_W), .PROD_W(PROD_W)) i_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .acc_clr (acc_clr),
    .md      (md),
    .re_c    (re_c),
    .im_c    (im_c),
    .dot_c   (dot_c),
    .acc_q   (acc_out)
  );

  assign cplx_ld = en && ((md == MD_CMUL) || (md == MD_CMAC));

  always_comb begin
    re_d = re_q;
    im_d = im_q;
    if (cplx_ld) begin
      re_d = re_c;
      im_d = im_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q <= '0;
      im_q <= '0;
    end else if (cplx_ld) begin
      re_q <= re_d;
      im_q <= im_d;
    end
  end

  assign re_out = re_q;
  assign im_out = im_q;

  // R8
  cplx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(re_out) && $stable(im_out)));

  // R5
  cplx_fir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && md == MD_FIR) |=> ($stable(re_out) && $stable(im_out)));

  // R6
  cplx_pow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && md == MD_POW) |=> ($stable(re_out) && $stable(im_out)));
endmodule

// File: tb/test_cmac_unit.sv
`timescale 1ns/1ps
module test_cmac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        acc_clr = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [15:0] re_out, im_out;
  logic [39:0] acc_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] m_re, m_im;
  logic [39:0] m_acc;
  string       m_tag = "R2";

  always #4 clk = ~clk;

  cmac_unit i_cmac_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .mode    (mode),
    .acc_clr (acc_clr),
    .op_a    (op_a),
    .op_b    (op_b),
    .re_out  (re_out),
    .im_out  (im_out),
    .acc_out (acc_out)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    int ia, qa, ib, qb;
    longint sum;
    logic [19:0] hi, lo;
    logic [39:0] base;
    if (!rst_n) begin
      m_re = '0; m_im = '0; m_acc = '0; m_tag = "R2";
    end else begin
      ia = int'($signed(op_a[15:8])); qa = int'($signed(op_a[7:0]));
      ib = int'($signed(op_b[15:8])); qb = int'($signed(op_b[7:0]));
      base = acc_clr ? 40'd0 : m_acc;
      if (!en) begin
        m_tag = acc_clr ? "R7" : "R8";
        if (acc_clr) m_acc = '0;
      end else begin
        case (mode)
          2'd0, 2'd1: begin
            m_re = 16'(ia * ib - qa * qb);
            m_im = 16'(ia * qb + qa * ib);
            if (mode == 2'd0) begin
              m_tag = "R3";
              m_acc = base;
            end else begin
              m_tag = "R4";
              hi = base[39:20] + {{4{m_re[15]}}, m_re};
              lo = base[19:0]  + {{4{m_im[15]}}, m_im};
              m_acc = {hi, lo};
            end
          end
          2'd2: begin
            m_tag = "R5";
            sum = longint'(ia * ib + qa * qb);
            m_acc = base + 40'(sum);
          end
          default: begin
            m_tag = "R6";
            sum = longint'(ia * ia + qa * qa);
            m_acc = base + 40'(sum);
          end
        endcase
        if (acc_clr) m_tag = "R7";
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(m_tag, "re_out",  {24'd0, re_out}, {24'd0, m_re});
    chk(m_tag, "im_out",  {24'd0, im_out}, {24'd0, m_im});
    chk(m_tag, "acc_out", acc_out, m_acc);
  endtask

  task automatic issue(input logic e, input logic [1:0] m, input logic c,
                       input logic [15:0] a, input logic [15:0] b);
    en = e; mode = m; acc_clr = c; op_a = a; op_b = b;
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_model();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset values
    chk("R2", "re_out reset",  {24'd0, re_out}, 40'd0);
    chk("R2", "im_out reset",  {24'd0, im_out}, 40'd0);
    chk("R2", "acc_out reset", acc_out, 40'd0);
    rst_n = 1'b1;
    tick();

    // R1 lane placement: I=3 in A, Q=5 in B -> im = 15
    issue(1, 2'd0, 0, 16'h0300, 16'h0005);
    tick();
    chk("R1", "I lane re", {24'd0, re_out}, 40'd0);
    chk("R1", "I lane im", {24'd0, im_out}, 40'd15);
    // R1 Q lanes only: re = -(2*7)
    issue(1, 2'd0, 0, 16'h0002, 16'h0007);
    tick();
    chk("R1", "Q lane re", {24'd0, re_out}, 40'h000000FFF2);

    // R9 not visible before edge, visible after
    issue(1, 2'd0, 0, 16'h0404, 16'h0400);
    #1;
    chk("R9", "early re", {24'd0, re_out}, 40'h000000FFF2);
    tick();
    chk("R9", "re one edge later", {24'd0, re_out}, 40'd16);

    // R3 imaginary wrap: (-128)(-128)*2 = 32768 -> 0x8000
    issue(1, 2'd0, 0, 16'h8080, 16'h8080);
    tick();
    chk("R3", "imag wrap", {24'd0, im_out}, 40'h0000008000);
    chk("R3", "real zero", {24'd0, re_out}, 40'd0);

    // R4 upper half wraps without touching lower half
    issue(1, 2'd1, 1, 16'h8080, 16'h807F);
    tick();
    for (int k = 1; k < 40; k++) begin
      issue(1, 2'd1, 0, 16'h8080, 16'h807F);
      tick();
    end
    chk("R4", "split halves", acc_out, {20'h3EC00, 20'h01400});

    // R8 idle with busy inputs
    issue(0, 2'd2, 0, 16'h7F7F, 16'h7F7F);
    tick();
    chk("R8", "idle acc", acc_out, {20'h3EC00, 20'h01400});

    // R5 signed dual tap
    issue(1, 2'd2, 1, 16'h02FF, 16'h0303);
    tick();
    chk("R5", "fir clr", acc_out, 40'd3);
    issue(1, 2'd2, 0, 16'hFF00, 16'h0500);
    tick();
    chk("R5", "fir negative", acc_out, 40'hFFFFFFFFFE);

    // R6 energy ignores op_b
    issue(1, 2'd3, 1, 16'h0304, 16'h7F80);
    tick();
    chk("R6", "energy", acc_out, 40'd25);
    issue(1, 2'd3, 0, 16'h0304, 16'h1234);
    tick();
    chk("R6", "energy b ignored", acc_out, 40'd50);

    // R7 idle clear
    issue(0, 2'd1, 1, 16'h1111, 16'h2222);
    tick();
    chk("R7", "idle clear", acc_out, 40'd0);

    // mixed traffic
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] a, b;
      logic [31:0] r;
      r = $urandom;
      a = 16'($urandom);
      b = 16'($urandom);
      if (r[3:2] == 2'd0) begin
        a = {r[4] ? 8'h80 : 8'h7F, r[5] ? 8'h80 : 8'h7F};
        b = {r[6] ? 8'h80 : 8'h7F, r[7] ? 8'h80 : 8'h7F};
      end
      issue(r[10:8] != 3'd0, r[1:0], r[15:12] == 4'd0, a, b);
      tick();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule